// File: doc/BRIEF.md
# FPGA Configuration Stream Loader

This controller moves a configuration image for a programmable logic device from a byte-wide image memory into the device's 16-bit configuration write port. A load begins with a one-cycle `start` strobe. The block first checks that the boot memory is present. Each attempt then drives three reset-style pulses: local bus reset, boot-memory reload and program. It waits for the target to raise its ready (INIT) status. Next it scans the image for a two-byte sync marker. From the marker onward it streams the bytes as big-endian 16-bit words and confirms after every word that the target is still ready. At the end it waits for the target to report ready and transfer-complete at the same time.

Any failure inside an attempt starts the whole sequence again, up to a bounded number of attempts. A successful load finishes with one more bus-reset and reload pair. The result is held on `done` or `error` until the next `start`. The image memory is read combinationally through `imgAddr`/`imgData`, and `imgLen` gives the number of valid bytes.

Top module: `cfg_stream_loader`

## Requirements
- R1: Every attempt drives `busResetPulse`, then `reloadPulse`, then `progPulse`, in that order. Each pulse is high for PULSE_CYC cycles, the pulses follow each other with no gap, and no two of them are ever high together.
- R2: After the program pulse, `statInit` is sampled at most POLL_MAX times, with POLL_GAP idle cycles between samples. If it is never seen high, the attempt fails, and the next attempt's bus reset begins POLL_MAX + (POLL_MAX-1)*POLL_GAP cycles after the program pulse falls.
- R3: Image bytes before the first occurrence of byte 0xFF directly followed by byte 0x20 are skipped. Streaming starts at that 0xFF byte. An image with no such pair writes no words.
- R4: Each word carries the earlier byte in bits 15:8 and the following byte in bits 7:0. If the streamed part has an odd length, the last word carries 0x00 in bits 7:0.
- R5: `cfgWrite` is high for exactly one cycle per word. Consecutive writes within an attempt are SETTLE_CYC+4 cycles apart, and this spacing includes a settling wait of SETTLE_CYC cycles.
- R6: `statInit` is sampled in the cycle after each write. If it is low, the attempt ends at once and no further words are written in that attempt.
- R7: After the last word, completion requires `statInit` and `statTxDone` to be high in the same sample, polled the same way as in R2. If they are not, the attempt fails.
- R8: At most MAX_TRIES attempts are made. When the last one fails, `error` is raised.
- R9: After a successful completion check, one more bus-reset pulse and one more reload pulse are driven, and then `done` is raised.
- R10: If `eepromPresent` is low at `start`, `error` is raised without any pulse or write.
- R11: `done` and `error` are never high together and hold until the next accepted `start`. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| eepromPresent | input | 1 | Boot memory present; low refuses the load |
| imgLen | input | AW+1 | Number of valid image bytes |
| imgAddr | output | AW | Image byte address |
| imgData | input | 8 | Image byte at `imgAddr` (combinational read) |
| statInit | input | 1 | Target ready/INIT status |
| statTxDone | input | 1 | Target transfer-complete status |
| busResetPulse | output | 1 | Local bus reset pulse |
| reloadPulse | output | 1 | Boot-memory reload pulse |
| progPulse | output | 1 | Target program pulse |
| cfgWrite | output | 1 | Configuration word write strobe |
| cfgWord | output | 16 | Configuration word |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load succeeded |
| error | output | 1 | Load failed or refused |

## Verification
The embedded assertions assume that the image memory and `imgLen` do not change while a load runs. One check relies on this: after the scan steps back to the marker, the addressed byte must read 0xFF. The bench writes every image and sets its length before pulsing `start`, and leaves both untouched until `done` or `error`. The target model changes `statInit` and `statTxDone` only on falling clock edges, so the controller never samples a status that changes at its own edge. The random images vary the preamble content, the marker position, whether a marker exists, and the parity of the payload.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam logic [7:0] SYNC_FIRST  = 8'hFF;
  localparam logic [7:0] SYNC_SECOND = 8'h20;
  localparam logic [7:0] PAD_BYTE    = 8'h00;

  typedef enum logic [4:0] {
    S_IDLE, S_RST, S_RLD, S_PRG, S_POLL_INIT, S_GAP_INIT, S_SCAN,
    S_SETTLE, S_FETCH_HI, S_FETCH_LO, S_WRITE, S_CHECK,
    S_POLL_FIN, S_GAP_FIN, S_POST_RST, S_POST_RLD, S_DONE, S_FAIL
  } ldState_t;

  typedef struct packed {
    logic ptrClr;
    logic scanStep;
    logic ptrRewind;
    logic loadHi;
    logic loadLo;
    logic tmrClr;
    logic pollClr;
    logic pollInc;
    logic tryClr;
    logic tryInc;
  } dpCmd_t;

  function automatic int maxOf3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int AW        = 10,
  parameter int TW        = 4,
  parameter int PW        = 6,
  parameter int RW        = 2,
  parameter int POLL_MAX  = 50,
  parameter int MAX_TRIES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic [AW:0]   imgLen,
  input  logic [7:0]    imgData,
  output logic [AW-1:0] imgAddr,
  output logic [15:0]   cfgWord,
  output logic          markHit,
  output logic          ptrAtEnd,
  output logic [TW-1:0] tmrCnt,
  output logic [PW-1:0] pollCnt,
  output logic [RW-1:0] tryCnt
);

  logic [AW:0]   ptr;
  logic          lastWasFirst;
  logic [15:0]   wordReg;
  localparam logic [TW-1:0] TMR_TOP = '1;

  assign imgAddr  = ptr[AW-1:0];
  assign ptrAtEnd = (ptr >= imgLen);
  assign markHit  = lastWasFirst && (imgData == SYNC_SECOND) && !ptrAtEnd;
  assign cfgWord  = wordReg;

  // byte pointer and marker tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr          <= '0;
      lastWasFirst <= 1'b0;
    end else if (cmd.ptrClr) begin
      ptr          <= '0;
      lastWasFirst <= 1'b0;
    end else if (cmd.ptrRewind) begin
      ptr          <= ptr - 1'b1;
      lastWasFirst <= 1'b0;
    end else if (cmd.scanStep) begin
      ptr          <= ptr + 1'b1;
      lastWasFirst <= (imgData == SYNC_FIRST);
    end else if (cmd.loadHi) begin
      ptr          <= ptr + 1'b1;
    end else if (cmd.loadLo && !ptrAtEnd) begin
      ptr          <= ptr + 1'b1;
    end
  end

  // word packing, earlier byte high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (cmd.loadHi) begin
      wordReg[15:8] <= imgData;
    end else if (cmd.loadLo) begin
      wordReg[7:0] <= ptrAtEnd ? PAD_BYTE : imgData;
    end
  end

  // cycles-in-state timer
  always_ff @(posedge clk) begin
    if (!rstN || cmd.tmrClr) tmrCnt <= '0;
    else if (tmrCnt != TMR_TOP) tmrCnt <= tmrCnt + 1'b1;
  end

  // poll and attempt counters
  always_ff @(posedge clk) begin
    if (!rstN || cmd.pollClr) pollCnt <= '0;
    else if (cmd.pollInc) pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.tryClr) tryCnt <= '0;
    else if (cmd.tryInc) tryCnt <= tryCnt + 1'b1;
  end

  a_r2_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(POLL_MAX));

  a_r8_try_bound: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt < RW'(MAX_TRIES));

  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loadLo && ptrAtEnd) |=> (cfgWord[7:0] == PAD_BYTE));

  a_r3_rewind_lands_on_sync: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ptrRewind |=> (imgData == SYNC_FIRST));

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int TW         = 4,
  parameter int PW         = 6,
  parameter int RW         = 2,
  parameter int PULSE_CYC  = 4,
  parameter int POLL_GAP   = 8,
  parameter int POLL_MAX   = 50,
  parameter int SETTLE_CYC = 2,
  parameter int MAX_TRIES  = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          eepromPresent,
  input  logic          statInit,
  input  logic          statTxDone,
  input  logic          markHit,
  input  logic          ptrAtEnd,
  input  logic [TW-1:0] tmrCnt,
  input  logic [PW-1:0] pollCnt,
  input  logic [RW-1:0] tryCnt,
  output dpCmd_t        cmd,
  output logic          busResetPulse,
  output logic          reloadPulse,
  output logic          progPulse,
  output logic          cfgWrite,
  output logic          busy,
  output logic          done,
  output logic          error
);

  localparam logic [TW-1:0] PULSE_LAST  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] GAP_LAST    = TW'(POLL_GAP - 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
  localparam logic [PW-1:0] POLL_LAST   = PW'(POLL_MAX - 1);
  localparam logic [RW-1:0] TRY_LAST    = RW'(MAX_TRIES - 1);

  ldState_t state, nextState;
  logic     attemptFail;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    cmd         = '0;
    attemptFail = 1'b0;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          cmd.tryClr = 1'b1;
          nextState  = eepromPresent ? S_RST : S_FAIL;
        end
      end
      S_RST: if (tmrCnt == PULSE_LAST) nextState = S_RLD;
      S_RLD: if (tmrCnt == PULSE_LAST) nextState = S_PRG;
      S_PRG: begin
        if (tmrCnt == PULSE_LAST) begin
          cmd.pollClr = 1'b1;
          nextState   = S_POLL_INIT;
        end
      end
      S_POLL_INIT: begin
        if (statInit) begin
          cmd.ptrClr = 1'b1;
          nextState  = S_SCAN;
        end else if (pollCnt == POLL_LAST) begin
          attemptFail = 1'b1;
        end else begin
          cmd.pollInc = 1'b1;
          nextState   = S_GAP_INIT;
        end
      end
      S_GAP_INIT: if (tmrCnt == GAP_LAST) nextState = S_POLL_INIT;
      S_SCAN: begin
        if (ptrAtEnd) begin
          cmd.pollClr = 1'b1;
          nextState   = S_POLL_FIN;
        end else if (markHit) begin
          cmd.ptrRewind = 1'b1;
          nextState     = S_SETTLE;
        end else begin
          cmd.scanStep = 1'b1;
        end
      end
      S_SETTLE: if (tmrCnt == SETTLE_LAST) nextState = S_FETCH_HI;
      S_FETCH_HI: begin
        cmd.loadHi = 1'b1;
        nextState  = S_FETCH_LO;
      end
      S_FETCH_LO: begin
        cmd.loadLo = 1'b1;
        nextState  = S_WRITE;
      end
      S_WRITE: nextState = S_CHECK;
      S_CHECK: begin
        if (!statInit) begin
          attemptFail = 1'b1;
        end else if (ptrAtEnd) begin
          cmd.pollClr = 1'b1;
          nextState   = S_POLL_FIN;
        end else begin
          nextState = S_SETTLE;
        end
      end
      S_POLL_FIN: begin
        if (statInit && statTxDone) begin
          nextState = S_POST_RST;
        end else if (pollCnt == POLL_LAST) begin
          attemptFail = 1'b1;
        end else begin
          cmd.pollInc = 1'b1;
          nextState   = S_GAP_FIN;
        end
      end
      S_GAP_FIN:  if (tmrCnt == GAP_LAST) nextState = S_POLL_FIN;
      S_POST_RST: if (tmrCnt == PULSE_LAST) nextState = S_POST_RLD;
      S_POST_RLD: if (tmrCnt == PULSE_LAST) nextState = S_DONE;
      default:    nextState = S_IDLE;
    endcase

    if (attemptFail) begin
      if (tryCnt == TRY_LAST) begin
        nextState = S_FAIL;
      end else begin
        cmd.tryInc = 1'b1;
        nextState  = S_RST;
      end
    end

    cmd.tmrClr = (nextState != state);
  end

  assign busResetPulse = (state == S_RST) || (state == S_POST_RST);
  assign reloadPulse   = (state == S_RLD) || (state == S_POST_RLD);
  assign progPulse     = (state == S_PRG);
  assign cfgWrite      = (state == S_WRITE);
  assign done          = (state == S_DONE);
  assign error         = (state == S_FAIL);
  assign busy          = !(state == S_IDLE || state == S_DONE || state == S_FAIL);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busResetPulse, reloadPulse, progPulse, cfgWrite}));

  a_r1_prog_after_reload: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progPulse) |-> $past(reloadPulse));

  a_r5_write_single: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !cfgWrite);

  a_r10_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !eepromPresent) |=> (error && !busy));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgld_pkg::*;
#(
  parameter int AW         = 10,
  parameter int PULSE_CYC  = 4,
  parameter int POLL_GAP   = 8,
  parameter int POLL_MAX   = 50,
  parameter int SETTLE_CYC = 2,
  parameter int MAX_TRIES  = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          eepromPresent,
  input  logic [AW:0]   imgLen,
  output logic [AW-1:0] imgAddr,
  input  logic [7:0]    imgData,
  input  logic          statInit,
  input  logic          statTxDone,
  output logic          busResetPulse,
  output logic          reloadPulse,
  output logic          progPulse,
  output logic          cfgWrite,
  output logic [15:0]   cfgWord,
  output logic          busy,
  output logic          done,
  output logic          error
);

  localparam int TMAX = maxOf3(PULSE_CYC, POLL_GAP, SETTLE_CYC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);
  localparam int RW   = $clog2(MAX_TRIES + 1);

  dpCmd_t          cmd;
  logic            markHit;
  logic            ptrAtEnd;
  logic [TW-1:0]   tmrCnt;
  logic [PW-1:0]   pollCnt;
  logic [RW-1:0]   tryCnt;

  cfgld_ctrl #(
    .TW(TW), .PW(PW), .RW(RW), .PULSE_CYC(PULSE_CYC), .POLL_GAP(POLL_GAP),
    .POLL_MAX(POLL_MAX), .SETTLE_CYC(SETTLE_CYC), .MAX_TRIES(MAX_TRIES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .eepromPresent(eepromPresent),
    .statInit(statInit), .statTxDone(statTxDone), .markHit(markHit),
    .ptrAtEnd(ptrAtEnd), .tmrCnt(tmrCnt), .pollCnt(pollCnt), .tryCnt(tryCnt),
    .cmd(cmd), .busResetPulse(busResetPulse), .reloadPulse(reloadPulse),
    .progPulse(progPulse), .cfgWrite(cfgWrite), .busy(busy), .done(done),
    .error(error)
  );

  cfgld_datapath #(
    .AW(AW), .TW(TW), .PW(PW), .RW(RW), .POLL_MAX(POLL_MAX), .MAX_TRIES(MAX_TRIES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .imgLen(imgLen), .imgData(imgData),
    .imgAddr(imgAddr), .cfgWord(cfgWord), .markHit(markHit), .ptrAtEnd(ptrAtEnd),
    .tmrCnt(tmrCnt), .pollCnt(pollCnt), .tryCnt(tryCnt)
  );

endmodule

// File: tb/test_cfg_stream_loader.sv
module test_cfg_stream_loader;

  localparam int AW      = 10;
  localparam int PULSE   = 4;
  localparam int GAP     = 8;
  localparam int PMAX    = 50;
  localparam int SETTLE  = 2;
  localparam int TRIES   = 3;
  localparam int MEMSZ   = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          eepromPresent = 1'b1;
  logic [AW:0]   imgLen = '0;
  logic [AW-1:0] imgAddr;
  logic [7:0]    imgData;
  logic          statInit = 1'b0;
  logic          statTxDone = 1'b0;
  logic          busResetPulse, reloadPulse, progPulse, cfgWrite;
  logic [15:0]   cfgWord;
  logic          busy, done, error;

  logic [7:0]  img [0:MEMSZ-1];
  logic [15:0] expWords [0:MEMSZ-1];
  logic [15:0] capWords [0:MEMSZ-1];
  int          expCount;

  int vectors = 0;
  int misses  = 0;

  // target model controls and observations
  int  initDelay = 0;
  bit  initNever = 1'b0;
  bit  txEnable  = 1'b1;
  int  dropWord  = 0;
  int  dropUpTo  = 0;
  int  attempts  = 0;
  int  wordCnt   = 0;
  int  gapBad    = 0;
  int  cyc       = 0;
  int  lastWr    = 0;
  int  delayCnt  = 0;
  bit  armed     = 1'b0;
  int  progFallCyc = 0;
  int  windowCyc   = -1;
  int  evLog [0:63];
  int  evN = 0;
  logic prevRst = 1'b0, prevRld = 1'b0, prevPrg = 1'b0;

  assign imgData = img[imgAddr];

  always #5 clk = ~clk;

  cfg_stream_loader #(
    .AW(AW), .PULSE_CYC(PULSE), .POLL_GAP(GAP), .POLL_MAX(PMAX),
    .SETTLE_CYC(SETTLE), .MAX_TRIES(TRIES)
  ) i_cfg_stream_loader (
    .clk(clk), .rstN(rstN), .start(start), .eepromPresent(eepromPresent),
    .imgLen(imgLen), .imgAddr(imgAddr), .imgData(imgData),
    .statInit(statInit), .statTxDone(statTxDone),
    .busResetPulse(busResetPulse), .reloadPulse(reloadPulse),
    .progPulse(progPulse), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .busy(busy), .done(done), .error(error)
  );

  // target model: observes outputs and updates status away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busResetPulse && !prevRst) begin
      if (evN < 64) evLog[evN] = 0;
      evN = evN + 1;
      if (windowCyc < 0 && progFallCyc > 0) windowCyc = cyc - progFallCyc;
    end
    if (reloadPulse && !prevRld) begin
      if (evN < 64) evLog[evN] = 1;
      evN = evN + 1;
    end
    if (progPulse && !prevPrg) begin
      if (evN < 64) evLog[evN] = 2;
      evN = evN + 1;
      attempts = attempts + 1;
      wordCnt = 0;
      armed = 1'b0;
      statInit <= 1'b0;
    end
    if (!progPulse && prevPrg) begin
      armed = 1'b1;
      delayCnt = initDelay;
      if (progFallCyc == 0) progFallCyc = cyc;
    end
    if (armed) begin
      if (delayCnt == 0) begin
        if (!initNever) statInit <= 1'b1;
        armed = 1'b0;
      end else begin
        delayCnt = delayCnt - 1;
      end
    end
    if (cfgWrite) begin
      if (wordCnt < MEMSZ) capWords[wordCnt] = cfgWord;
      if (wordCnt > 0 && (cyc - lastWr) != SETTLE + 4) gapBad = gapBad + 1;
      lastWr = cyc;
      wordCnt = wordCnt + 1;
      if (dropWord != 0 && wordCnt == dropWord && attempts <= dropUpTo)
        statInit <= 1'b0;
    end
    statTxDone <= txEnable && (wordCnt == expCount) && !progPulse;
    prevRst = busResetPulse;
    prevRld = reloadPulse;
    prevPrg = progPulse;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      misses = misses + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected word list from the image (R3, R4)
  task automatic computeExpected();
    int s;
    s = -1;
    for (int i = 0; i + 1 < int'(imgLen); i++) begin
      if (s < 0 && img[i] == 8'hFF && img[i+1] == 8'h20) s = i;
    end
    expCount = 0;
    if (s >= 0) begin
      for (int i = s; i < int'(imgLen); i += 2) begin
        expWords[expCount] = {img[i], (i + 1 < int'(imgLen)) ? img[i+1] : 8'h00};
        expCount = expCount + 1;
      end
    end
  endtask

  task automatic resetModel();
    attempts = 0; wordCnt = 0; evN = 0; gapBad = 0; lastWr = 0;
    progFallCyc = 0; windowCyc = -1;
  endtask

  // returns 1 on done, 0 on error; watchdog counts as a miss
  task automatic runLoad(output bit okDone);
    int guard;
    resetModel();
    computeExpected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!(done || error) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) check(1'b0, "watchdog", "load hung", guard, 0);
    okDone = done;
  endtask

  task automatic checkWords(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < expCount; i++) if (capWords[i] !== expWords[i]) bad++;
    check(wordCnt == expCount, req, "word count", wordCnt, expCount);
    check(bad == 0, req, "word mismatches", bad, 0);
  endtask

  task automatic checkSuccessLog(input int nAtt);
    int bad;
    bad = 0;
    if (evN != 3 * nAtt + 2) bad++;
    for (int i = 0; i < evN && i < 64; i++)
      if (evLog[i] != ((i < 3 * nAtt) ? (i % 3) : (i - 3 * nAtt))) bad++;
    check(bad == 0, "R1/R9", "pulse order errors", bad, 0);
  endtask

  task automatic loadImage(input int len);
    imgLen = (AW+1)'(len);
  endtask

  task automatic setDefaults();
    initDelay = 0; initNever = 1'b0; txEnable = 1'b1;
    dropWord = 0; dropUpTo = 0; eepromPresent = 1'b1;
  endtask

  initial begin : main
    bit ok;
    int n;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < MEMSZ; i++) img[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!done && !error && !busy, "R11", "idle flags after reset",
          {29'd0, done, error, busy}, 0);

    // R3/R4/R5/R9: preamble with near-miss patterns, even payload
    setDefaults();
    img[0] = 8'h12; img[1] = 8'hFF; img[2] = 8'h00; img[3] = 8'hFF;
    img[4] = 8'hFF; img[5] = 8'h20; img[6] = 8'hAB; img[7] = 8'hCD;
    img[8] = 8'h01; img[9] = 8'h02;
    loadImage(10);
    runLoad(ok);
    check(ok, "R9", "done after clean load", int'(ok), 1);
    check(expCount == 3, "R3", "stream starts at sync byte", expCount, 3);
    checkWords("R4");
    checkSuccessLog(1);
    check(gapBad == 0, "R5", "write spacing errors", gapBad, 0);
    repeat (20) @(negedge clk);
    check(done && !busy, "R11", "done holds", int'(done), 1);

    // R4: odd payload pads low byte
    setDefaults();
    img[10] = 8'h7E;
    loadImage(11);
    runLoad(ok);
    check(ok, "R4", "done odd image", int'(ok), 1);
    checkWords("R4");
    check(capWords[3] == 16'h7E00, "R4", "padded last word", int'(capWords[3]), 16'h7E00);

    // R3: no marker, sync byte only at the end
    setDefaults();
    img[0] = 8'h20; img[1] = 8'h20; img[2] = 8'hFF;
    loadImage(3);
    runLoad(ok);
    check(ok && wordCnt == 0, "R3", "no marker writes nothing", wordCnt, 0);

    // R2: late INIT within the poll window
    setDefaults();
    for (int i = 0; i < 8; i++) img[i] = 8'(i * 37 + 1);
    img[8] = 8'hFF; img[9] = 8'h20; img[10] = 8'h55; img[11] = 8'hAA;
    loadImage(12);
    initDelay = 40 * (GAP + 1);
    runLoad(ok);
    check(ok && attempts == 1, "R2", "late INIT single attempt", attempts, 1);
    checkWords("R2");

    // R2/R8: INIT never appears
    setDefaults();
    initNever = 1'b1;
    runLoad(ok);
    check(error && !done, "R8", "error after INIT timeout", int'(error), 1);
    check(attempts == TRIES, "R8", "attempt count", attempts, TRIES);
    check(windowCyc == PMAX + (PMAX - 1) * GAP, "R2", "poll window cycles",
          windowCyc, PMAX + (PMAX - 1) * GAP);
    check(wordCnt == 0, "R2", "no writes without INIT", wordCnt, 0);

    // R6: INIT drops on first attempt, retry succeeds
    setDefaults();
    dropWord = 1; dropUpTo = 1;
    runLoad(ok);
    check(ok && attempts == 2, "R6", "retry after INIT drop", attempts, 2);
    checkWords("R6");

    // R6/R8: INIT drops on every attempt at word 2
    setDefaults();
    img[12] = 8'h01; img[13] = 8'h02; img[14] = 8'h03;
    loadImage(15);
    dropWord = 2; dropUpTo = 99;
    runLoad(ok);
    check(error && attempts == TRIES, "R8", "error after drops", attempts, TRIES);
    check(wordCnt == 2, "R6", "words after abort", wordCnt, 2);

    // R7: all words written but transfer-done never seen
    setDefaults();
    txEnable = 1'b0;
    runLoad(ok);
    check(error && attempts == TRIES, "R7", "error without txdone", attempts, TRIES);
    checkWords("R7");

    // R10: boot memory absent
    setDefaults();
    eepromPresent = 1'b0;
    runLoad(ok);
    check(error && evN == 0 && attempts == 0, "R10", "refused pulses", evN, 0);

    // R11: start during a load is ignored
    setDefaults();
    resetModel();
    computeExpected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
    check(done && attempts == 1, "R11", "start ignored while busy", attempts, 1);
    checkSuccessLog(1);

    // random images
    for (int t = 0; t < 16; t++) begin
      int len, pos;
      setDefaults();
      len = 4 + int'($urandom % 120);
      for (int i = 0; i < len; i++) img[i] = 8'($urandom);
      if (($urandom % 4) != 0) begin
        pos = int'($urandom % (len - 1));
        img[pos] = 8'hFF; img[pos+1] = 8'h20;
      end
      if (($urandom % 3) == 0) begin
        dropWord = 1 + int'($urandom % 3); dropUpTo = 1;
      end
      loadImage(len);
      runLoad(ok);
      check(ok, "R9", "random load done", int'(ok), 1);
      if (dropWord == 0 || expCount < dropWord) checkWords("R4");
      else checkWords("R6");
      check(gapBad == 0, "R5", "random write spacing", gapBad, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    misses = misses + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule